// File: doc/BRIEF.md
# Iterative Shift-Subtract Unsigned Divider

This block divides an unsigned dividend by a narrower or equal-width unsigned divisor, one quotient bit per clock. A start pulse captures both operands and the algorithm choice. The dividend goes into a shift register that slowly turns into the quotient. A wide accumulator holds the partial remainder, and the divisor stays in its own register for the whole run. On every step the accumulator and the quotient register shift left together. One shared add/subtract unit then forms the new partial remainder, and its sign gives the next quotient bit.

A mode input selects the algorithm.
- **Restoring:** every step subtracts the divisor, and a negative result puts the old accumulator back.
- **Non-restoring:** a negative result is kept. The next step then adds the divisor instead of subtracting it. One closing addition repairs a negative final remainder.

The accumulator has a guard bit so that dividends wider than the divisor work. A sign bit sits above the guard bit for non-restoring operation. A parameter appends zero bits on the right of the dividend, which gives extra quotient bits below the binary point.

Top module: `iter_divider`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all zero.
- R2: With `mode`=0 (restoring), a non-zero divisor B and a dividend A give `quotient` = floor(A·2^F / B) and `remainder` = (A·2^F) mod B, where F = FRAC_W. The quotient is DVD_W+F bits wide: its upper DVD_W bits are the integer part and its lower F bits are the fraction.
- R3: With `mode`=1 (non-restoring), the same operands give the same quotient and remainder as R2, and the remainder always lies in [0, B).
- R4: Let N = DVD_W+FRAC_W. With a non-zero divisor, `done` rises N clock edges after the edge that accepted `start` in restoring mode. In non-restoring mode it rises after N+1 edges when the quotient LSB is 0 (a correction addition is needed) and after N edges otherwise.
- R5: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `done` is a single-cycle pulse.
- R6: A `start` pulse while `busy` is high is ignored: the running division finishes with its original operands.
- R7: A zero divisor gives `div_zero`=1, an all-ones quotient and `remainder` equal to the low DVS_W bits of the dividend. `done` rises on the very edge that accepts `start`, and `busy` never rises.
- R8: After `done`, `quotient`, `remainder` and `div_zero` hold their values until the next accepted `start`.
- R9: `mode`, `dividend` and `divisor` are sampled only when `start` is accepted. Changing them during a run has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (accepted only when not busy) |
| mode | input | 1 | 0 = restoring, 1 = non-restoring |
| dividend | input | DVD_W | Unsigned dividend |
| divisor | input | DVS_W | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results become valid |
| quotient | output | DVD_W+FRAC_W | Quotient, integer bits above FRAC_W fraction bits |
| remainder | output | DVS_W | Non-negative remainder |
| div_zero | output | 1 | The last accepted divisor was zero |

## Verification
Both algorithms are driven with the same seeded random operand pairs, so any disagreement between them shows up as a mismatch against the floor-and-modulo reference.

Directed pairs cover the corners of the operand space:
- A divisor of 1 exercises the largest quotient.
- A divisor larger than the dividend gives a pure fraction.
- An all-ones dividend over the largest divisor drives the guard bit.
- A zero divisor takes the exception path.

Quotients with an even LSB separate the corrected non-restoring latency from the uncorrected one. Runs that toggle the inputs mid-division, or pulse `start` while busy, show whether operands are captured only once.

// File: rtl/divq_pkg.sv
package divq_pkg;
   typedef enum logic {
      ALG_RESTORE = 1'b0,
      ALG_NONREST = 1'b1
   } alg_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } state_e;
endpackage

// File: rtl/divq_step.sv
// One add/subtract step on the partial remainder.
module divq_step #(
   parameter int AW           = 8,
   parameter int SHARED_ADDER = 1
) (
   input  logic [AW-1:0] opa,
   input  logic [AW-1:0] opb,
   input  logic          do_add,
   input  logic          restore_en,
   output logic [AW-1:0] acc_nxt,
   output logic          qbit,
   output logic          neg
);
   logic [AW-1:0] sum;

   generate
      if (SHARED_ADDER != 0) begin : g_shared
         // single carry chain: invert operand and inject carry for subtract
         logic [AW-1:0] opb_x;
         logic [AW-1:0] cin_v;
         assign opb_x = opb ^ {AW{~do_add}};
         assign cin_v = {{(AW-1){1'b0}}, ~do_add};
         assign sum   = opa + opb_x + cin_v;
      end else begin : g_split
         // separate adder and subtracter, result selected afterwards
         logic [AW-1:0] s_add;
         logic [AW-1:0] s_sub;
         assign s_add = opa + opb;
         assign s_sub = opa - opb;
         assign sum   = do_add ? s_add : s_sub;
      end
   endgenerate

   assign neg     = sum[AW-1];
   assign qbit    = ~neg;
   assign acc_nxt = (restore_en && neg) ? opa : sum;
endmodule

// File: rtl/divq_path.sv
// Accumulator, quotient shift register and divisor register.
module divq_path
   import divq_pkg::*;
#(
   parameter int DVD_W        = 8,
   parameter int DVS_W        = 6,
   parameter int FRAC_W       = 2,
   parameter int SHARED_ADDER = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    dvs_zero,
   input  logic                    step,
   input  logic                    fix,
   input  logic                    first,
   input  logic [DVD_W-1:0]        dividend,
   input  logic [DVS_W-1:0]        divisor,
   input  logic                    mode_in,
   output logic [DVD_W+FRAC_W-1:0] quo,
   output logic [DVS_W-1:0]        rem,
   output logic                    dz,
   output alg_e                    alg,
   output logic                    step_neg,
   output logic [DVS_W-1:0]        dvs_held
);
   // guard bit for a 1 shifted out of the remainder, plus a sign bit
   localparam int AW = DVS_W + 2;
   localparam int QW = DVD_W + FRAC_W;

   alg_e              alg_q;
   logic [AW-1:0]     acc_q;
   logic [QW-1:0]     q_q;
   logic [DVS_W-1:0]  dvs_q;
   logic              prev_q;
   logic              dz_q;

   logic [AW-1:0]     shifted;
   logic [AW-1:0]     opa;
   logic [AW-1:0]     opb;
   logic [AW-1:0]     acc_nxt;
   logic              qbit;
   logic              do_add;
   logic              restore_en;

   assign shifted    = {acc_q[AW-2:0], q_q[QW-1]};
   assign opa        = fix ? acc_q : shifted;
   assign opb        = {2'b00, dvs_q};
   assign do_add     = fix | ((alg_q == ALG_NONREST) & ~first & ~prev_q);
   assign restore_en = (alg_q == ALG_RESTORE) & ~fix;

   divq_step #(
      .AW           (AW),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_step (
      .opa        (opa),
      .opb        (opb),
      .do_add     (do_add),
      .restore_en (restore_en),
      .acc_nxt    (acc_nxt),
      .qbit       (qbit),
      .neg        (step_neg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alg_q  <= ALG_RESTORE;
         acc_q  <= '0;
         q_q    <= '0;
         dvs_q  <= '0;
         prev_q <= 1'b0;
         dz_q   <= 1'b0;
      end else if (load) begin
         alg_q  <= alg_e'(mode_in);
         dvs_q  <= divisor;
         prev_q <= 1'b0;
         if (dvs_zero) begin
            acc_q <= AW'(dividend[DVS_W-1:0]);
            q_q   <= '1;
            dz_q  <= 1'b1;
         end else begin
            acc_q <= '0;
            q_q   <= QW'(dividend) << FRAC_W;
            dz_q  <= 1'b0;
         end
      end else if (step) begin
         acc_q  <= acc_nxt;
         q_q    <= {q_q[QW-2:0], qbit};
         prev_q <= qbit;
      end else if (fix) begin
         acc_q  <= acc_nxt;
      end
   end

   assign quo      = q_q;
   assign rem      = acc_q[DVS_W-1:0];
   assign dz       = dz_q;
   assign alg      = alg_q;
   assign dvs_held = dvs_q;
endmodule

// File: rtl/divq_ctrl.sv
// Sequencer: idle, N iterations, optional correction.
module divq_ctrl
   import divq_pkg::*;
#(
   parameter int N = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic dvs_zero,
   input  alg_e alg,
   input  logic step_neg,
   output logic load,
   output logic step,
   output logic fix,
   output logic first,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(N + 1);

   state_e        state_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;
   logic          last;

   assign last  = (cnt_q == CW'(N - 1));
   assign load  = (state_q == ST_IDLE) && start;
   assign step  = (state_q == ST_RUN);
   assign fix   = (state_q == ST_FIX);
   assign first = (cnt_q == '0);
   assign busy  = (state_q != ST_IDLE);
   assign done  = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (dvs_zero) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= ST_RUN;
                     cnt_q   <= '0;
                  end
               end
            end
            ST_RUN: begin
               cnt_q <= cnt_q + CW'(1);
               if (last) begin
                  if ((alg == ALG_NONREST) && step_neg) begin
                     state_q <= ST_FIX;
                  end else begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            ST_FIX: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
   import divq_pkg::*;
#(
   parameter int DVD_W        = 8,
   parameter int DVS_W        = 6,
   parameter int FRAC_W       = 2,
   parameter int SHARED_ADDER = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    mode,
   input  logic [DVD_W-1:0]        dividend,
   input  logic [DVS_W-1:0]        divisor,
   output logic                    busy,
   output logic                    done,
   output logic [DVD_W+FRAC_W-1:0] quotient,
   output logic [DVS_W-1:0]        remainder,
   output logic                    div_zero
);
   localparam int QW = DVD_W + FRAC_W;
   localparam int N  = QW;

   generate
      if (DVS_W < 2) begin : g_bad_dvs
         $error("iter_divider: DVS_W must be at least 2");
      end
      if (DVD_W < DVS_W) begin : g_bad_dvd
         $error("iter_divider: DVD_W must not be smaller than DVS_W");
      end
      if (FRAC_W < 0) begin : g_bad_frac
         $error("iter_divider: FRAC_W must be non-negative");
      end
      if ((SHARED_ADDER != 0) && (SHARED_ADDER != 1)) begin : g_bad_add
         $error("iter_divider: SHARED_ADDER must be 0 or 1");
      end
   endgenerate

   logic             dvs_zero;
   logic             load;
   logic             step;
   logic             fix;
   logic             first;
   logic             step_neg;
   alg_e             alg_q;
   logic [DVS_W-1:0] dvs_q;

   assign dvs_zero = (divisor == '0);

   divq_ctrl #(
      .N (N)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .dvs_zero (dvs_zero),
      .alg      (alg_q),
      .step_neg (step_neg),
      .load     (load),
      .step     (step),
      .fix      (fix),
      .first    (first),
      .busy     (busy),
      .done     (done)
   );

   divq_path #(
      .DVD_W        (DVD_W),
      .DVS_W        (DVS_W),
      .FRAC_W       (FRAC_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .dvs_zero (dvs_zero),
      .step     (step),
      .fix      (fix),
      .first    (first),
      .dividend (dividend),
      .divisor  (divisor),
      .mode_in  (mode),
      .quo      (quotient),
      .rem      (remainder),
      .dz       (div_zero),
      .alg      (alg_q),
      .step_neg (step_neg),
      .dvs_held (dvs_q)
   );
endmodule

// File: rtl/iter_divider_chk.sv
module iter_divider_chk
   import divq_pkg::*;
#(
   parameter int DVD_W  = 8,
   parameter int DVS_W  = 6,
   parameter int FRAC_W = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic [DVS_W-1:0]        divisor,
   input logic                    busy,
   input logic                    done,
   input logic [DVD_W+FRAC_W-1:0] quotient,
   input logic [DVS_W-1:0]        remainder,
   input logic                    div_zero,
   input logic [DVS_W-1:0]        dvs_q,
   input alg_e                    alg_q
);
   localparam int N  = DVD_W + FRAC_W;
   localparam int LW = $clog2(N + 2) + 1;

   logic [LW-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_q <= '0;
      else if (start && !busy)   lat_q <= '0;
      else if (busy)             lat_q <= lat_q + LW'(1);
   end

   p_rem_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_zero) |-> (remainder < dvs_q));

   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_zero) |->
         ((alg_q == ALG_RESTORE) && (lat_q == LW'(N))) ||
         ((alg_q == ALG_NONREST) && ((lat_q == LW'(N)) || (lat_q == LW'(N + 1)))));

   p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (divisor != '0)) |=> (busy && !done));

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   p_held_ops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(dvs_q) && $stable(alg_q)));

   p_zero_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (divisor == '0)) |=> (done && div_zero && !busy && (&quotient)));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
endmodule

bind iter_divider iter_divider_chk #(
   .DVD_W  (DVD_W),
   .DVS_W  (DVS_W),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .divisor   (divisor),
   .busy      (busy),
   .done      (done),
   .quotient  (quotient),
   .remainder (remainder),
   .div_zero  (div_zero),
   .dvs_q     (dvs_q),
   .alg_q     (alg_q)
);

// File: tb/iter_divider_test.sv
`timescale 1ns/1ps
module iter_divider_test;
   localparam int DVD_W  = 8;
   localparam int DVS_W  = 6;
   localparam int FRAC_W = 2;
   localparam int QW     = DVD_W + FRAC_W;
   localparam int N      = QW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              mode = 1'b0;
   logic [DVD_W-1:0]  dividend = '0;
   logic [DVS_W-1:0]  divisor = '0;
   logic              busy;
   logic              done;
   logic [QW-1:0]     quotient;
   logic [DVS_W-1:0]  remainder;
   logic              div_zero;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   iter_divider #(
      .DVD_W  (DVD_W),
      .DVS_W  (DVS_W),
      .FRAC_W (FRAC_W)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .dividend  (dividend),
      .divisor   (divisor),
      .busy      (busy),
      .done      (done),
      .quotient  (quotient),
      .remainder (remainder),
      .div_zero  (div_zero)
   );

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [QW-1:0] ref_quo(input logic [DVD_W-1:0] a, input logic [DVS_W-1:0] b);
      longint num;
      num = longint'(a) << FRAC_W;
      if (b == '0) return '1;
      return QW'(num / longint'(b));
   endfunction

   function automatic logic [DVS_W-1:0] ref_rem(input logic [DVD_W-1:0] a, input logic [DVS_W-1:0] b);
      longint num;
      num = longint'(a) << FRAC_W;
      if (b == '0) return a[DVS_W-1:0];
      return DVS_W'(num % longint'(b));
   endfunction

   // poke: 0 none, 1 change inputs during run (R9), 2 also pulse start (R6)
   task automatic run_case(input logic m, input logic [DVD_W-1:0] a,
                           input logic [DVS_W-1:0] b, input int poke);
      logic [QW-1:0]    eq;
      logic [DVS_W-1:0] er;
      int               lat;
      int               exp_lat;
      string            tag;
      eq = ref_quo(a, b);
      er = ref_rem(a, b);
      if (b == '0)               exp_lat = 0;
      else if (m && !eq[0])      exp_lat = N + 1;
      else                       exp_lat = N;
      if (poke == 2)             tag = "R6";
      else if (poke == 1)        tag = "R9";
      else if (b == '0)          tag = "R7";
      else if (m)                tag = "R3";
      else                       tag = "R2";

      @(negedge clk);
      start = 1'b1; mode = m; dividend = a; divisor = b;
      @(negedge clk);
      start = 1'b0;
      if (poke != 0) begin
         mode = ~m; dividend = ~a; divisor = b ^ 6'h2A;
      end
      lat = 0;
      while (!done && lat < N + 6) begin
         if (lat == 1 && b != '0) chk("R5", "busy during run", busy, 1);
         start = (poke == 2 && lat == 2) ? 1'b1 : 1'b0;
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      chk("R4", "latency", lat, exp_lat);
      chk(tag, "quotient", quotient, eq);
      chk(tag, "remainder", remainder, er);
      chk(b == '0 ? "R7" : tag, "div_zero", div_zero, (b == '0) ? 1 : 0);
      if (b == '0) chk("R7", "busy stays low", busy, 0);
      else         chk("R5", "busy low at done", busy, 0);
      dividend = DVD_W'($urandom);
      divisor  = DVS_W'($urandom);
      mode     = ~mode;
      @(negedge clk);
      chk("R5", "done single pulse", done, 0);
      @(negedge clk);
      @(negedge clk);
      chk("R8", "quotient held", quotient, eq);
      chk("R8", "remainder held", remainder, er);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "done after reset", done, 0);
      chk("R1", "div_zero after reset", div_zero, 0);
      chk("R1", "quotient after reset", quotient, 0);
      chk("R1", "remainder after reset", remainder, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int m = 0; m < 2; m++) begin
         run_case(m[0], 8'd255, 6'd1,  0);   // divisor of 1
         run_case(m[0], 8'd255, 6'd63, 0);   // all ones, guard bit
         run_case(m[0], 8'd5,   6'd40, 0);   // divisor above dividend
         run_case(m[0], 8'd0,   6'd7,  0);
         run_case(m[0], 8'd200, 6'd3,  0);
         run_case(m[0], 8'd1,   6'd63, 0);
         run_case(m[0], 8'd255, 6'd0,  0);   // zero divisor
         run_case(m[0], 8'd0,   6'd0,  0);
         run_case(m[0], 8'd173, 6'd11, 1);
         run_case(m[0], 8'd99,  6'd13, 2);
      end

      for (int i = 0; i < 120; i++) begin
         logic [DVD_W-1:0] a;
         logic [DVS_W-1:0] b;
         a = DVD_W'($urandom);
         b = DVS_W'($urandom_range(63, 1));
         run_case(i[0], a, b, 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule